// File: doc/BRIEF.md
# Frame Alignment Overhead Inserter

This block sits in the transmit path of an optical transport framer. It receives a byte-wide frame stream where the alignment overhead has not been filled in yet. With the stream come a frame-start strobe, which marks the first byte of each frame, and a multiframe-start strobe. At each frame boundary the block writes the fixed alignment pattern and a multiframe sequence byte. Every other byte passes through unchanged. All outputs are delayed by one clock.

The block counts the row and column of every outgoing byte within the 4-row frame. Later stages, such as error-correction insertion, use this position to find their own regions without a second frame counter. The multiframe byte is a counter that advances once per frame. A multiframe-start strobe on a frame boundary forces it back to zero.

Top module: `fa_ovh_inserter`

## Requirements
- R1: While reset is high, the outputs are as follows: `dout` is 0x00, `fs_out` is 0, and the position outputs show the last byte of a frame (row ROWS-1, column COLS-1). The multiframe counter then holds 0xFF, so the first frame that arrives without a multiframe strobe carries 0x00.
- R2: Until the first `fs_in` after reset, no overhead is written. Every byte appears on `dout` unchanged, one clock later.
- R3: In a frame that starts with `fs_in`, the bytes at row 0, columns 0 to 2 leave as 0xF6, and the bytes at columns 3 to 5 leave as 0x28, whatever was on the input.
- R4: Row 0, column 6 of each frame carries the multiframe byte. If `mfs_in` is high together with `fs_in`, that frame's byte is 0x00.
- R5: In a frame that starts without `mfs_in`, the multiframe byte equals the previous frame's value plus one, and it wraps from 0xFF to 0x00.
- R6: `mfs_in` has no effect on a cycle where `fs_in` is low.
- R7: Once framing is established, every byte outside row 0, columns 0 to 6, appears on `dout` unchanged, one clock after it entered.
- R8: `fs_out` repeats `fs_in` one clock later, aligned with the first byte of the frame on `dout`.
- R9: `row_out` and `col_out` give the position of the byte on `dout`. The column counts from 0 to COLS-1. The row then advances and wraps to 0 after row ROWS-1.
- R10: A `fs_in` that arrives before the frame has ended restarts the position at row 0, column 0. Overhead is written from that byte on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Frame stream byte with empty overhead |
| fs_in | input | 1 | Frame-start strobe, high with the first byte of a frame |
| mfs_in | input | 1 | Multiframe-start strobe, honoured only together with fs_in |
| dout | output | 8 | Byte with overhead inserted, one clock after din |
| fs_out | output | 1 | Frame-start strobe aligned with dout |
| row_out | output | $clog2(ROWS) | Row of the byte on dout |
| col_out | output | $clog2(COLS) | Column of the byte on dout |

## Verification
On every cycle, the assertions check the following:
- `fs_out` always lines up with position zero.
- The column steps by one between frame starts.
- The alignment bytes are forced once framing holds.
- The multiframe counter changes only at frame starts, and then only by an increment or a clear.

Some behaviours only the bench scenarios can show:
- The counter values over hundreds of frames, including the 0xFF to 0x00 wrap.
- That a multiframe strobe between frame starts is ignored.
- That payload bytes survive unchanged under random data.
- That an early frame start realigns both the position and the insertion.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam logic [7:0] ALIGN_HI   = 8'hF6;
    localparam logic [7:0] ALIGN_LO   = 8'h28;
    localparam int unsigned HI_END    = 3;
    localparam int unsigned LO_END    = 6;
    localparam int unsigned MF_COL    = 6;
    localparam logic [7:0] MF_RESET   = 8'hFF;

    typedef enum logic [1:0] {
        BK_PASS  = 2'd0,
        BK_ALHI  = 2'd1,
        BK_ALLO  = 2'd2,
        BK_MFRM  = 2'd3
    } byte_kind_e;

    function automatic byte_kind_e classify(input logic en, input logic first_row,
                                            input int unsigned col);
        byte_kind_e k;
        k = BK_PASS;
        if (en && first_row) begin
            if (col < HI_END)       k = BK_ALHI;
            else if (col < LO_END)  k = BK_ALLO;
            else if (col == MF_COL) k = BK_MFRM;
        end
        return k;
    endfunction

endpackage

// File: rtl/fa_pos_tracker.sv
module fa_pos_tracker #(
    parameter int ROWS = 4,
    parameter int COLS = 4080,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fs,
    output logic [RW-1:0] cur_row,
    output logic [CW-1:0] cur_col,
    output logic [RW-1:0] row_q,
    output logic [CW-1:0] col_q
);
    localparam logic [RW-1:0] LAST_R = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_C = CW'(COLS - 1);

    always_comb begin
        if (fs) begin
            cur_row = '0;
            cur_col = '0;
        end else if (col_q == LAST_C) begin
            cur_col = '0;
            cur_row = (row_q == LAST_R) ? '0 : row_q + 1'b1;
        end else begin
            cur_col = col_q + 1'b1;
            cur_row = row_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= LAST_R;
            col_q <= LAST_C;
        end else begin
            row_q <= cur_row;
            col_q <= cur_col;
        end
    end

    // R9
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!fs && col_q != LAST_C) |=> (col_q == $past(col_q) + 1'b1));

endmodule

// File: rtl/fa_mf_counter.sv
module fa_mf_counter
    import fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fs,
    input  logic       mfs,
    output logic [7:0] mf_q
);
    always_ff @(posedge clk) begin
        if (rst)       mf_q <= MF_RESET;
        else if (fs)   mf_q <= mfs ? 8'h00 : mf_q + 8'h01;
    end

    // R6
    mf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fs |=> $stable(mf_q));

    // R5
    mf_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fs && !mfs) |=> (mf_q == $past(mf_q) + 8'h01));

    // R4
    mf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fs && mfs) |=> (mf_q == 8'h00));

endmodule

// File: rtl/fa_ovh_inserter.sv
module fa_ovh_inserter
    import fa_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4080,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    din,
    input  logic          fs_in,
    input  logic          mfs_in,
    output logic [7:0]    dout,
    output logic          fs_out,
    output logic [RW-1:0] row_out,
    output logic [CW-1:0] col_out
);
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic [7:0]    mf_q;
    logic          framed_q;
    logic          framed_now;
    byte_kind_e    kind;
    logic [7:0]    next_byte;

    fa_pos_tracker #(.ROWS(ROWS), .COLS(COLS)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .fs      (fs_in),
        .cur_row (cur_row),
        .cur_col (cur_col),
        .row_q   (row_out),
        .col_q   (col_out)
    );

    fa_mf_counter u_mf (
        .clk  (clk),
        .rst  (rst),
        .fs   (fs_in),
        .mfs  (mfs_in),
        .mf_q (mf_q)
    );

    assign framed_now = framed_q | fs_in;

    always_comb begin
        kind = classify(framed_now, cur_row == '0, 32'(cur_col));
        unique case (kind)
            BK_ALHI: next_byte = ALIGN_HI;
            BK_ALLO: next_byte = ALIGN_LO;
            BK_MFRM: next_byte = mf_q;
            default: next_byte = din;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            framed_q <= 1'b0;
            dout     <= 8'h00;
            fs_out   <= 1'b0;
        end else begin
            framed_q <= framed_now;
            dout     <= next_byte;
            fs_out   <= fs_in;
        end
    end

    // R8
    fs_pos_chk: assert property (@(posedge clk) disable iff (rst)
        fs_out |-> (row_out == '0 && col_out == '0));

    // R3
    align_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (framed_q && row_out == '0 && 32'(col_out) < HI_END) |-> (dout == ALIGN_HI));

    // R3
    align_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (framed_q && row_out == '0 && 32'(col_out) >= HI_END && 32'(col_out) < LO_END)
        |-> (dout == ALIGN_LO));

    // R2
    unframed_chk: assert property (@(posedge clk) disable iff (rst)
        !framed_q |-> (dout == $past(din)));

endmodule

// File: tb/tb_fa_ovh_inserter.sv
module tb_fa_ovh_inserter;
    localparam int ROWS = 4;
    localparam int COLS = 40;
    localparam int FLEN = ROWS * COLS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic       fs_in = 1'b0;
    logic       mfs_in = 1'b0;
    logic [7:0] dout;
    logic       fs_out;
    logic [1:0] row_out;
    logic [5:0] col_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_r = ROWS - 1;
    int exp_c = COLS - 1;
    int exp_mf = 255;
    bit framed = 0;

    always #2 clk = ~clk;

    fa_ovh_inserter #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst(rst), .din(din), .fs_in(fs_in), .mfs_in(mfs_in),
        .dout(dout), .fs_out(fs_out), .row_out(row_out), .col_out(col_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_byte(int r, int c, int d, int mf, bit fr);
        if (!fr || r != 0) return d;
        if (c < 3) return 8'hF6;
        if (c < 6) return 8'h28;
        if (c == 6) return mf;
        return d;
    endfunction

    function automatic string tag_of(int r, int c, bit fr);
        if (!fr) return "R2";
        if (r == 0 && c < 6) return "R3";
        if (r == 0 && c == 6) return "R4/R5";
        return "R7";
    endfunction

    // Drive one byte, then sample its result one clock later.
    task automatic send(logic [7:0] d, bit fs, bit mfs, string ptag);
        int e;
        din = d; fs_in = fs; mfs_in = mfs;
        if (fs) begin
            exp_r = 0; exp_c = 0; framed = 1;
            exp_mf = mfs ? 0 : (exp_mf + 1) % 256;
        end else begin
            exp_c++;
            if (exp_c == COLS) begin
                exp_c = 0;
                exp_r = (exp_r + 1) % ROWS;
            end
        end
        e = exp_byte(exp_r, exp_c, d, exp_mf, framed);
        @(posedge clk); #1;
        check((ptag != "") ? ptag : tag_of(exp_r, exp_c, framed), dout, e);
        check("R8", fs_out, fs);
        check("R9", row_out, exp_r);
        check("R9", col_out, exp_c);
        din = 8'h00; fs_in = 0; mfs_in = 0;
    endtask

    task automatic frame(bit mfs, int len, bit stray_mfs);
        for (int k = 0; k < len; k++) begin
            bit m;
            m = (k == 0) ? mfs : (stray_mfs && ($urandom % 8 == 0));
            send(8'($urandom), k == 0, m, "");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", dout, 0);
        check("R1", fs_out, 0);
        check("R1", row_out, ROWS - 1);
        check("R1", col_out, COLS - 1);
        rst = 0;

        // R2: no framing yet, bytes pass; R6: stray mfs has no effect
        for (int k = 0; k < 20; k++) send(8'($urandom), 0, k % 5 == 0, "");

        // R5: first frame without mfs carries 0x00, then increments
        for (int f = 0; f < 4; f++) frame(0, FLEN, 1);
        // R4: clear by strobe, directed overhead-looking input
        send(8'hF6, 1, 1, "R4");
        for (int k = 1; k < FLEN; k++) send((k % 2) ? 8'h00 : 8'hFF, 0, 0, "");
        // R5 wrap: 260 frames without a clear, stray mfs sprinkled (R6)
        for (int f = 0; f < 260; f++) frame(0, FLEN, 1);
        // R10: early frame start realigns position and insertion
        frame(0, 50, 0);
        frame(0, 13, 0);
        frame(1, FLEN, 0);
        frame(0, FLEN, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule